// File: doc/BRIEF.md
# Register access command channel

This block gives software one channel for reading and writing a remote space of 16-bit registers. Software places a 32-bit command word in the command register. The word says whether the access is a read or a write, gives the half-word address and, for a write, the data. A small state machine accepts the command and passes it downstream. When a read completes, the machine keeps the returned data in the status word and stays parked there until software writes the valid-clear register. Software polls the status word for the read data, the current state code, a request-pending flag, a link sync-idle flag and an init-done flag. A command that arrives while an earlier one is still in flight is dropped and latches a sticky error flag.

The downstream side runs over an internal valid/ready request channel to a behavioural remote register model. The model answers after a configurable number of cycles. A request, once raised, keeps its address and data stable until the model takes it. The model takes a new request only when it is idle. It has no response back-pressure: the channel always takes the acknowledge in the cycle it is offered. On the software side nothing stalls. Writes to the command register are either taken or ignored, and the state code is the only flow control.

Top module: `regacc_channel`

## Requirements
- R1: Command word layout: bit 31 = 1 selects a write, 0 a read. Bits [30:16] hold the half-word address (byte address divided by two). Bits [15:0] hold the write data. The remote model holds 32 registers at half-word addresses 0 to 31. A read of any higher address returns 0, and a write to one is dropped, with no aliasing onto the low registers.
- R2: Status word layout: read data in [15:0], state code in [18:16], request-pending in bit 19, sync-idle in bit 20, init-done in bit 21. Bits [31:22] read 0.
- R3: State codes are IDLE=0, REQ=2, WAIT (for downstream idle)=4 and VCLR (wait for valid-clear)=6. An accepted command enters REQ on the next edge, then WAIT on the edge after that.
- R4: A command is taken only in IDLE. A command written in any other state changes nothing in the transaction and sets the error flag.
- R5: A read ends in VCLR with the returned data in status [15:0]. The machine stays in VCLR until a valid-clear write with bit 0 = 1, which returns it to IDLE on the next edge. A valid-clear write with bit 0 = 0, or one made outside VCLR, has no effect.
- R6: A write updates the remote register and returns from WAIT straight to IDLE, never entering VCLR.
- R7: Request-pending is 1 only in REQ. Sync-idle is 0 from the edge that takes a command until the edge that takes the downstream acknowledge, and 1 otherwise.
- R8: The error flag stays set until a control write with bit 2 = 1 clears it.
- R9: Init-done in status follows control bit 1 from the edge after the control write.
- R10: Control bit 0 is the channel enable. While it is 0, command writes are ignored and do not set the error flag.
- R11: With latency L, the state code reads 4 for exactly L cycles and moves on at the (L+1)-th edge after the command edge.
- R12: After reset the status word is 0x0010_0000 (only sync-idle set), the error flag is 0, and enable and init-done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Target register: 0 command, 1 valid-clear, 2 control |
| sw_wdata | input | 32 | Software write data |
| status | output | 32 | Status word |
| err_flag | output | 1 | Sticky error for a command refused while busy |

## Verification
The hardest case to reach from the ports is a command that collides with a transaction already in flight. The second write has to land in the one REQ cycle or inside the short WAIT window. The stimulus issues a write and then, on the very next cycle, another command to a different address. A later read-back then shows that the second command never reached the remote register. The same cycle-accurate model also follows the parked VCLR state, so that commands and zero-valued clears arriving there are compared cycle by cycle.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd2,
    ST_WAIT = 3'd4,
    ST_VCLR = 3'd6
  } chan_state_e;

  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_VCLR = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTL_EN_BIT     = 0;
  localparam int CTL_INIT_BIT   = 1;
  localparam int CTL_ERRCLR_BIT = 2;

endpackage

// File: rtl/regacc_ctrl.sv
module regacc_ctrl
  import regacc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_we,
  input  logic [1:0] sw_sel,
  input  logic [2:0] ctl_bits,
  input  logic       idle,
  output logic       init_done,
  output logic       err_flag,
  output logic       cmd_fire,
  output logic       vclr_fire
);

  logic chan_en;
  logic cmd_hit;
  logic ctl_hit;

  assign cmd_hit   = sw_we && (sw_sel == SEL_CMD);
  assign ctl_hit   = sw_we && (sw_sel == SEL_CTRL);
  assign cmd_fire  = cmd_hit && chan_en && idle;
  assign vclr_fire = sw_we && (sw_sel == SEL_VCLR) && ctl_bits[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_en   <= 1'b0;
      init_done <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      if (ctl_hit) begin
        chan_en   <= ctl_bits[CTL_EN_BIT];
        init_done <= ctl_bits[CTL_INIT_BIT];
      end
      if (cmd_hit && chan_en && !idle) begin
        err_flag <= 1'b1;
      end else if (ctl_hit && ctl_bits[CTL_ERRCLR_BIT]) begin
        err_flag <= 1'b0;
      end
    end
  end

  // R8: error flag only falls on an explicit clear
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(ctl_hit && ctl_bits[CTL_ERRCLR_BIT])) |=> err_flag);

  // R10: nothing is accepted on a cycle after the channel was turned off
  p_off_no_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && !ctl_bits[CTL_EN_BIT]) |=> !cmd_fire);

endmodule

// File: rtl/regacc_fsm.sv
module regacc_fsm
  import regacc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 32,
  localparam int ADDR_W = CMD_W - 1 - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              vclr_fire,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_wr,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output chan_state_e       state,
  output logic [DATA_W-1:0] rdata,
  output logic              req_pend,
  output logic              sync_idle
);

  chan_state_e       state_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              pend_q;
  logic              sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      pend_q  <= 1'b0;
      sync_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (cmd_fire) begin
            wr_q    <= cmd_word[CMD_W-1];
            addr_q  <= cmd_word[CMD_W-2:DATA_W];
            wdata_q <= cmd_word[DATA_W-1:0];
            pend_q  <= 1'b1;
            sync_q  <= 1'b0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (dn_ready) begin
            pend_q  <= 1'b0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            sync_q <= 1'b1;
            if (wr_q) begin
              state_q <= ST_IDLE;
            end else begin
              rdata_q <= rsp_data;
              state_q <= ST_VCLR;
            end
          end
        end
        ST_VCLR: begin
          if (vclr_fire) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dn_valid  = (state_q == ST_REQ);
  assign dn_wr     = wr_q;
  assign dn_addr   = addr_q;
  assign dn_wdata  = wdata_q;
  assign state     = state_q;
  assign rdata     = rdata_q;
  assign req_pend  = pend_q;
  assign sync_idle = sync_q;

  // R3: only the four defined codes appear
  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) || (state_q == ST_REQ) ||
    (state_q == ST_WAIT) || (state_q == ST_VCLR));

  // R4: a new transaction starts only out of IDLE
  p_req_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ && $past(state_q) != ST_REQ) |-> $past(state_q) == ST_IDLE);

  // R6: a write never parks waiting for the clear
  p_write_skips_vclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VCLR && $past(state_q) != ST_VCLR) |-> !wr_q);

  // R5: parked read holds state and data until cleared
  p_vclr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VCLR && !vclr_fire) |=> (state_q == ST_VCLR) && $stable(rdata_q));

  // R7: link reported busy through the whole transaction
  p_sync_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REQ || state_q == ST_WAIT) |-> !sync_q);

  // R1: request fields stay put while not yet taken
  p_req_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> dn_valid && $stable(dn_addr) && $stable(dn_wdata));

endmodule

// File: rtl/regacc_remote.sv
module regacc_remote #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 15,
  parameter int REM_AW  = 5,
  parameter int LATENCY = 3,
  localparam int DEPTH  = 1 << REM_AW,
  localparam int CW     = $clog2(LATENCY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dn_valid,
  output logic              dn_ready,
  input  logic              dn_wr,
  input  logic [ADDR_W-1:0] dn_addr,
  input  logic [DATA_W-1:0] dn_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              in_range;
  logic [REM_AW-1:0] idx;

  assign idx = addr_q[REM_AW-1:0];

  generate
    if (ADDR_W > REM_AW) begin : g_upper_decode
      assign in_range = (addr_q[ADDR_W-1:REM_AW] == '0);
    end else begin : g_full_decode
      assign in_range = 1'b1;
    end
  endgenerate

  assign dn_ready  = !busy_q;
  assign rsp_valid = busy_q && (cnt_q == '0);
  assign rsp_data  = in_range ? mem[idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (dn_valid && dn_ready) begin
      busy_q  <= 1'b1;
      cnt_q   <= CW'(LATENCY - 1);
      wr_q    <= dn_wr;
      addr_q  <= dn_addr;
      wdata_q <= dn_wdata;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        if (wr_q && in_range) mem[idx] <= wdata_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R11: latency counter never exceeds its programmed start
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CW'(LATENCY - 1)));

endmodule

// File: rtl/regacc_channel.sv
module regacc_channel
  import regacc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CMD_W   = 32,
  parameter int REM_AW  = 5,
  parameter int LATENCY = 3,
  localparam int ADDR_W = CMD_W - 1 - DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [1:0]       sw_sel,
  input  logic [CMD_W-1:0] sw_wdata,
  output logic [CMD_W-1:0] status,
  output logic             err_flag
);

  chan_state_e       state;
  logic              idle;
  logic              init_done;
  logic              cmd_fire;
  logic              vclr_fire;
  logic              dn_valid;
  logic              dn_ready;
  logic              dn_wr;
  logic [ADDR_W-1:0] dn_addr;
  logic [DATA_W-1:0] dn_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic [DATA_W-1:0] rdata;
  logic              req_pend;
  logic              sync_idle;

  assign idle = (state == ST_IDLE);

  regacc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (sw_we),
    .sw_sel    (sw_sel),
    .ctl_bits  (sw_wdata[2:0]),
    .idle      (idle),
    .init_done (init_done),
    .err_flag  (err_flag),
    .cmd_fire  (cmd_fire),
    .vclr_fire (vclr_fire)
  );

  regacc_fsm #(.DATA_W(DATA_W), .CMD_W(CMD_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (cmd_fire),
    .cmd_word  (sw_wdata),
    .vclr_fire (vclr_fire),
    .dn_valid  (dn_valid),
    .dn_ready  (dn_ready),
    .dn_wr     (dn_wr),
    .dn_addr   (dn_addr),
    .dn_wdata  (dn_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .state     (state),
    .rdata     (rdata),
    .req_pend  (req_pend),
    .sync_idle (sync_idle)
  );

  regacc_remote #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .REM_AW (REM_AW),
    .LATENCY(LATENCY)
  ) u_remote (
    .clk       (clk),
    .rst_n     (rst_n),
    .dn_valid  (dn_valid),
    .dn_ready  (dn_ready),
    .dn_wr     (dn_wr),
    .dn_addr   (dn_addr),
    .dn_wdata  (dn_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  always_comb begin
    status                     = '0;
    status[DATA_W-1:0]         = rdata;
    status[DATA_W+2:DATA_W]    = state;
    status[DATA_W+3]           = req_pend;
    status[DATA_W+4]           = sync_idle;
    status[DATA_W+5]           = init_done;
  end

  // R7: pending flag and REQ state coincide at the pins
  p_pend_is_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_pend |-> (state == ST_REQ));

endmodule

// File: tb/sim_regacc_channel.sv
module sim_regacc_channel;

  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [1:0]  sw_sel = 2'd0;
  logic [31:0] sw_wdata = 32'd0;
  logic [31:0] status;
  logic        err_flag;

  int n_checks = 0;
  int n_fails = 0;
  int cyc = 0;
  bit live = 1'b0;

  // reference model state
  int m_state, m_cnt, m_data, m_addr, m_wd;
  bit m_wr, m_err, m_en, m_done;
  int m_mem [32];

  regacc_channel #(.LATENCY(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .status(status), .err_flag(err_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_status();
    logic [31:0] s;
    s = 32'd0;
    s[15:0]  = m_data[15:0];
    s[18:16] = m_state[2:0];
    s[19]    = (m_state == 2);
    s[20]    = !(m_state == 2 || m_state == 4);
    s[21]    = m_done;
    return s;
  endfunction

  always @(posedge clk) begin
    bit cmd, ctl, vc;
    cyc++;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_data = 0; m_addr = 0; m_wd = 0;
      m_wr = 0; m_err = 0; m_en = 0; m_done = 0;
      for (int i = 0; i < 32; i++) m_mem[i] = 0;
    end else begin
      cmd = sw_we && sw_sel == 2'd0;
      ctl = sw_we && sw_sel == 2'd2;
      vc  = sw_we && sw_sel == 2'd1 && sw_wdata[0];
      if (cmd && m_en && m_state != 0) m_err = 1;
      else if (ctl && sw_wdata[2]) m_err = 0;
      case (m_state)
        0: if (cmd && m_en) begin
             m_wr = sw_wdata[31]; m_addr = int'(sw_wdata[30:16]);
             m_wd = int'(sw_wdata[15:0]); m_state = 2;
           end
        2: begin m_state = 4; m_cnt = LAT - 1; end
        4: if (m_cnt == 0) begin
             if (m_wr) begin
               if (m_addr < 32) m_mem[m_addr] = m_wd;
               m_state = 0;
             end else begin
               m_data = (m_addr < 32) ? m_mem[m_addr] : 0;
               m_state = 6;
             end
           end else m_cnt--;
        6: if (vc) m_state = 0;
        default: m_state = 0;
      endcase
      if (ctl) begin m_en = sw_wdata[0]; m_done = sw_wdata[1]; end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R3 status vs model", status, model_status());
      chk("R4 error vs model", {31'd0, err_flag}, {31'd0, m_err});
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  task automatic sw_op(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0; sw_wdata = 32'd0;
  endtask

  function automatic logic [31:0] mk_cmd(input bit wr, input int half, input int d);
    return {wr, 15'(half), 16'(d)};
  endfunction

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input int half, input logic [15:0] exp, input string tag);
    sw_op(2'd0, mk_cmd(1'b0, half, 0));
    idle_wait(LAT);
    chk({tag, " code before ack"}, {29'd0, status[18:16]}, 32'd4);
    idle_wait(1);
    chk({tag, " parked code"}, {29'd0, status[18:16]}, 32'd6);
    chk({tag, " read data"}, {16'd0, status[15:0]}, {16'd0, exp});
    sw_op(2'd1, 32'd1);
    chk({tag, " back to idle"}, {29'd0, status[18:16]}, 32'd0);
  endtask

  initial begin
    idle_wait(3);
    rst_n = 1'b1;
    live = 1'b1;
    @(negedge clk);
    chk("R12 reset status", status, 32'h0010_0000);
    chk("R12 reset error", {31'd0, err_flag}, 32'd0);

    // R10: disabled channel ignores commands without error
    sw_op(2'd0, mk_cmd(1'b1, 3, 16'h1111));
    idle_wait(2);
    chk("R10 disabled stays idle", {29'd0, status[18:16]}, 32'd0);
    chk("R10 disabled no error", {31'd0, err_flag}, 32'd0);

    // enable + init-done
    sw_op(2'd2, 32'd3);
    chk("R9 init-done set", {31'd0, status[21]}, 32'd1);

    // R6 write transaction, R7 flags
    sw_op(2'd0, mk_cmd(1'b1, 5, 16'hBEEF));
    chk("R7 pending in REQ", {28'd0, status[20:17]}, {28'd0, 4'b0_1_0_1});
    chk("R3 code REQ", {29'd0, status[18:16]}, 32'd2);
    idle_wait(1);
    chk("R3 code WAIT", {29'd0, status[18:16]}, 32'd4);
    chk("R7 sync low in WAIT", {30'd0, status[20:19]}, 32'd0);
    idle_wait(LAT);
    chk("R6 write back to idle", {29'd0, status[18:16]}, 32'd0);
    chk("R7 sync idle after ack", {31'd0, status[20]}, 32'd1);

    // R5 / R11 / R1 read back
    do_read(5, 16'hBEEF, "R11 R1 read half 5");

    // R4 command while parked, R5 zero clear ignored
    sw_op(2'd0, mk_cmd(1'b0, 5, 0));
    idle_wait(LAT + 1);
    sw_op(2'd0, mk_cmd(1'b1, 7, 16'h7777));
    chk("R4 error on busy command", {31'd0, err_flag}, 32'd1);
    chk("R4 state still parked", {29'd0, status[18:16]}, 32'd6);
    sw_op(2'd1, 32'd0);
    idle_wait(2);
    chk("R5 zero clear ignored", {29'd0, status[18:16]}, 32'd6);
    chk("R5 data held", {16'd0, status[15:0]}, 32'h0000_BEEF);
    sw_op(2'd1, 32'd1);
    chk("R5 clear to idle", {29'd0, status[18:16]}, 32'd0);
    idle_wait(2);
    chk("R8 error sticky", {31'd0, err_flag}, 32'd1);
    sw_op(2'd2, 32'd7);
    chk("R8 error cleared", {31'd0, err_flag}, 32'd0);

    // R4 collision during REQ: second command must not reach remote
    @(negedge clk);
    sw_we = 1'b1; sw_sel = 2'd0; sw_wdata = mk_cmd(1'b1, 9, 16'hA0A0);
    @(negedge clk);
    sw_wdata = mk_cmd(1'b1, 10, 16'hC3C3);
    @(negedge clk);
    sw_we = 1'b0; sw_wdata = 32'd0;
    chk("R4 error on in-flight collision", {31'd0, err_flag}, 32'd1);
    idle_wait(LAT + 1);
    do_read(9, 16'hA0A0, "R6 first write landed");
    do_read(10, 16'h0000, "R4 dropped command");
    sw_op(2'd2, 32'd7);

    // R1 out-of-range and top register
    sw_op(2'd0, mk_cmd(1'b1, 40, 16'h1234));
    idle_wait(LAT + 1);
    sw_op(2'd0, mk_cmd(1'b1, 31, 16'h5A5A));
    idle_wait(LAT + 1);
    do_read(40, 16'h0000, "R1 out-of-range read");
    do_read(8, 16'h0000, "R1 no aliasing");
    do_read(31, 16'h5A5A, "R1 top register");

    // R9 init-done clear, R10 disable again
    sw_op(2'd2, 32'd1);
    chk("R9 init-done cleared", {31'd0, status[21]}, 32'd0);
    sw_op(2'd2, 32'd0);
    sw_op(2'd0, mk_cmd(1'b0, 31, 0));
    idle_wait(LAT + 2);
    chk("R10 disabled read ignored", {29'd0, status[18:16]}, 32'd0);
    chk("R2 upper bits zero", {22'd0, status[31:22]}, 32'd0);

    live = 1'b0;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule